// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This unit keeps the control state of one warp: a program counter shared by all lanes and an active-lane mask. The warp takes three kinds of event. An advance moves the PC on by one instruction. A branch comes with a per-lane taken vector, a target PC and a rejoin PC. A rejoin happens when a path reaches the PC at which its lanes meet again. When the active lanes agree on a branch, only the PC moves. When they disagree, the unit records on a stack what it needs to finish both paths and to merge them later. It runs the taken lanes first, then the fall-through lanes, and then restores the mask held before the branch.

Each stack entry holds a resume PC, a resume mask and a stop PC. The stop PC is the PC at which the path now running ends. A divergent branch pushes up to two entries in one cycle. The first is a rejoin entry that holds the pre-branch mask. The second is a fall-through entry. A PC update whose new value equals the top entry's stop PC is replaced by a pop in the same cycle, with no bubble. A pop can load a PC that already equals the next entry's stop PC, which happens when nested branches share a rejoin PC. In that case the unit spends one settle cycle popping again.

A controller state machine has three states:
- `ST_CONV`: the stack is empty and all lanes are active.
- `ST_DIV`: at least one entry is pending.
- `ST_OVF`: a push found too little room, so the unit raises the overflow flag and freezes until reset.

The transitions are:
- `ST_CONV`→`ST_DIV` on any push.
- `ST_DIV`→`ST_CONV` when the last entry is popped.
- `ST_CONV`/`ST_DIV`→`ST_OVF` on a push without room.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the PC equals RESET_PC (0), the mask is all ones (32 lanes) and the overflow flag is 0.
- R2: An advance with no branch sets the PC to PC+4 on the next clock and leaves the mask unchanged.
- R3: A branch is uniform-taken when every active lane has its taken bit set. Bits of inactive lanes are ignored. The PC becomes the target and the mask is unchanged.
- R4: A branch is uniform-not-taken when no active lane has its taken bit set. The PC becomes PC+4 and the mask is unchanged.
- R5: On a divergent branch, the next cycle shows PC = target and mask = taken AND active, so the taken path runs first.
- R6: When a PC update on the taken path would land on the rejoin PC, that same clock instead sets PC = branch PC+4 and mask = not-taken active lanes.
- R7: When a PC update on the fall-through path would land on the rejoin PC, that same clock sets PC = rejoin PC and restores the pre-branch mask.
- R8: A divergent branch whose target equals its rejoin PC runs only the fall-through lanes at PC+4, then rejoins as in R7. If both target and PC+4 equal the rejoin PC, the PC moves to the rejoin PC and the mask is unchanged.
- R9: A divergent branch whose PC+4 equals its rejoin PC runs only the taken lanes at the target, then rejoins as in R7.
- R10: If the PC already equals the top entry's stop PC, the next clock pops that entry and any event presented in that cycle is ignored. With an empty stack no pop happens.
- R11: With DEPTH=8, four nested two-path divergences fit. A push without room sets the overflow flag, after which PC and mask stay frozen and events are ignored until reset.
- R12: When advance and branch are presented together, the branch decides the next PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Non-branch instruction retired: advance PC |
| br_valid_i | input | 1 | Branch event this cycle |
| br_taken_i | input | LANES | Per-lane taken vector |
| br_target_i | input | PC_W | Branch target PC |
| br_rejoin_i | input | PC_W | PC where the branch's paths meet |
| pc_o | output | PC_W | Current warp PC |
| mask_o | output | LANES | Current active-lane mask |
| overflow_o | output | 1 | Sticky stack-overflow flag |

## Verification
Two functions can share a clock edge. The first is the PC update from an advance or uniform branch. The second is the pop caused because the new PC equals the top entry's stop PC. The bench provokes this by advancing, or by branching uniformly, onto the rejoin PC on both the taken and the fall-through path. It judges the result by the PC and mask seen one clock later: they must be the resumed entry's values, never the rejoin PC with the partial mask. The other overlaps are the settle pop that coincides with a presented advance, and a branch presented together with an advance; both are judged the same way.

// File: rtl/simt_rs_pkg.sv
package simt_rs_pkg;

    typedef enum logic [1:0] {
        ST_CONV = 2'd0,
        ST_DIV  = 2'd1,
        ST_OVF  = 2'd2
    } rs_state_e;

    typedef enum logic [2:0] {
        BR_UNI_T       = 3'd0,
        BR_UNI_N       = 3'd1,
        BR_JUMP_JOIN   = 3'd2,
        BR_SPLIT_BOTH  = 3'd3,
        BR_SPLIT_TAKEN = 3'd4,
        BR_SPLIT_FALL  = 3'd5
    } br_kind_e;

endpackage

// File: rtl/simt_rs_classify.sv
module simt_rs_classify #(
    parameter int LANES = 32,
    parameter int PC_W  = 32
) (
    input  logic [LANES-1:0]          cur_mask,
    input  logic [LANES-1:0]          taken_vec,
    input  logic [PC_W-1:0]           target_pc,
    input  logic [PC_W-1:0]           rejoin_pc,
    input  logic [PC_W-1:0]           fall_pc,
    output simt_rs_pkg::br_kind_e     kind,
    output logic [LANES-1:0]          take_mask,
    output logic [LANES-1:0]          fall_mask
);
    import simt_rs_pkg::*;

    logic tgt_at_join;
    logic fall_at_join;

    always_comb begin
        take_mask    = taken_vec & cur_mask;
        fall_mask    = ~taken_vec & cur_mask;
        tgt_at_join  = (target_pc == rejoin_pc);
        fall_at_join = (fall_pc == rejoin_pc);

        if (fall_mask == '0) begin
            kind = BR_UNI_T;
        end else if (take_mask == '0) begin
            kind = BR_UNI_N;
        end else if (tgt_at_join && fall_at_join) begin
            kind = BR_JUMP_JOIN;
        end else if (tgt_at_join) begin
            kind = BR_SPLIT_FALL;
        end else if (fall_at_join) begin
            kind = BR_SPLIT_TAKEN;
        end else begin
            kind = BR_SPLIT_BOTH;
        end
    end

endmodule

// File: rtl/simt_rs_stack.sv
module simt_rs_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                push_cnt,
    input  logic [PC_W-1:0]           a_pc,
    input  logic [LANES-1:0]          a_mask,
    input  logic [PC_W-1:0]           a_stop,
    input  logic [PC_W-1:0]           b_pc,
    input  logic [LANES-1:0]          b_mask,
    input  logic [PC_W-1:0]           b_stop,
    input  logic                      pop,
    output logic [PC_W-1:0]           top_pc,
    output logic [LANES-1:0]          top_mask,
    output logic [PC_W-1:0]           top_stop,
    output logic                      empty,
    output logic                      last_one,
    output logic                      has_one,
    output logic                      has_two
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PC_W-1:0]  slot_pc   [DEPTH];
    logic [LANES-1:0] slot_mask [DEPTH];
    logic [PC_W-1:0]  slot_stop [DEPTH];
    logic [LVL_W-1:0] level;
    logic [IDX_W-1:0] top_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                slot_pc[s]   <= '0;
                slot_mask[s] <= '0;
                slot_stop[s] <= '0;
            end
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (push_cnt != 2'd0 && level == LVL_W'(s)) begin
                    slot_pc[s]   <= a_pc;
                    slot_mask[s] <= a_mask;
                    slot_stop[s] <= a_stop;
                end else if (push_cnt == 2'd2 && (level + LVL_W'(1)) == LVL_W'(s)) begin
                    slot_pc[s]   <= b_pc;
                    slot_mask[s] <= b_mask;
                    slot_stop[s] <= b_stop;
                end
            end
            if (push_cnt != 2'd0) begin
                level <= level + LVL_W'(push_cnt);
            end else if (pop) begin
                level <= level - LVL_W'(1);
            end
        end
    end

    always_comb begin
        top_idx  = IDX_W'(level - LVL_W'(1));
        top_pc   = slot_pc[top_idx];
        top_mask = slot_mask[top_idx];
        top_stop = slot_stop[top_idx];
        empty    = (level == '0);
        last_one = (level == LVL_W'(1));
        has_one  = (level < LVL_W'(DEPTH));
        has_two  = (level < LVL_W'(DEPTH - 1));
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level != '0)); // R6
    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && push_cnt != 2'd0)); // R10
    AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt == 2'd2) |-> has_two); // R11
    AST_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (level == $past(level) - LVL_W'(1))); // R7

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
    parameter int              LANES     = 32,
    parameter int              PC_W      = 32,
    parameter int              DEPTH     = 8,
    parameter int              INSN_STEP = 4,
    parameter logic [PC_W-1:0] RESET_PC  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              br_valid_i,
    input  logic [LANES-1:0]  br_taken_i,
    input  logic [PC_W-1:0]   br_target_i,
    input  logic [PC_W-1:0]   br_rejoin_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [LANES-1:0]  mask_o,
    output logic              overflow_o
);
    import simt_rs_pkg::*;

    localparam logic [PC_W-1:0] STEP_PC = PC_W'(INSN_STEP);

    rs_state_e         st_q, st_n;
    logic [PC_W-1:0]   pc_q, pc_n;
    logic [LANES-1:0]  mask_q, mask_n;

    logic [PC_W-1:0]   fall_pc;
    br_kind_e          kind;
    logic [LANES-1:0]  take_mask, fall_mask;

    logic [1:0]        push_cnt;
    logic              pop;
    logic [PC_W-1:0]   top_pc, top_stop;
    logic [LANES-1:0]  top_mask;
    logic              empty, last_one, has_one, has_two;

    logic              settle;
    logic              upd_en;
    logic [PC_W-1:0]   upd_pc;
    logic              ovf_hit;

    assign fall_pc = pc_q + STEP_PC;
    assign settle  = !empty && (pc_q == top_stop);

    simt_rs_classify #(.LANES(LANES), .PC_W(PC_W)) u_classify (
        .cur_mask  (mask_q),
        .taken_vec (br_taken_i),
        .target_pc (br_target_i),
        .rejoin_pc (br_rejoin_i),
        .fall_pc   (fall_pc),
        .kind      (kind),
        .take_mask (take_mask),
        .fall_mask (fall_mask)
    );

    simt_rs_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_cnt (push_cnt),
        .a_pc     (br_rejoin_i),
        .a_mask   (mask_q),
        .a_stop   (br_rejoin_i),
        .b_pc     (fall_pc),
        .b_mask   (fall_mask),
        .b_stop   (br_rejoin_i),
        .pop      (pop),
        .top_pc   (top_pc),
        .top_mask (top_mask),
        .top_stop (top_stop),
        .empty    (empty),
        .last_one (last_one),
        .has_one  (has_one),
        .has_two  (has_two)
    );

    // Next-state logic
    always_comb begin
        st_n     = st_q;
        pc_n     = pc_q;
        mask_n   = mask_q;
        push_cnt = 2'd0;
        pop      = 1'b0;
        upd_en   = 1'b0;
        upd_pc   = pc_q;
        ovf_hit  = 1'b0;

        unique case (st_q)
            ST_CONV, ST_DIV: begin
                if (settle) begin
                    pop    = 1'b1;
                    pc_n   = top_pc;
                    mask_n = top_mask;
                end else if (br_valid_i) begin
                    unique case (kind)
                        BR_UNI_T: begin
                            upd_en = 1'b1;
                            upd_pc = br_target_i;
                        end
                        BR_UNI_N: begin
                            upd_en = 1'b1;
                            upd_pc = fall_pc;
                        end
                        BR_JUMP_JOIN: begin
                            upd_en = 1'b1;
                            upd_pc = br_rejoin_i;
                        end
                        BR_SPLIT_BOTH: begin
                            if (!has_two) begin
                                ovf_hit = 1'b1;
                            end else begin
                                push_cnt = 2'd2;
                                pc_n     = br_target_i;
                                mask_n   = take_mask;
                            end
                        end
                        BR_SPLIT_TAKEN: begin
                            if (!has_one) begin
                                ovf_hit = 1'b1;
                            end else begin
                                push_cnt = 2'd1;
                                pc_n     = br_target_i;
                                mask_n   = take_mask;
                            end
                        end
                        BR_SPLIT_FALL: begin
                            if (!has_one) begin
                                ovf_hit = 1'b1;
                            end else begin
                                push_cnt = 2'd1;
                                pc_n     = fall_pc;
                                mask_n   = fall_mask;
                            end
                        end
                        default: begin
                        end
                    endcase
                end else if (adv_i) begin
                    upd_en = 1'b1;
                    upd_pc = fall_pc;
                end

                if (upd_en) begin
                    if (!empty && upd_pc == top_stop) begin
                        pop    = 1'b1;
                        pc_n   = top_pc;
                        mask_n = top_mask;
                    end else begin
                        pc_n = upd_pc;
                    end
                end

                if (ovf_hit) begin
                    st_n = ST_OVF;
                end else if (push_cnt != 2'd0) begin
                    st_n = ST_DIV;
                end else if (pop && last_one) begin
                    st_n = ST_CONV;
                end
            end
            ST_OVF: begin
                st_n = ST_OVF;
            end
            default: begin
                st_n = ST_OVF;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_CONV;
            pc_q   <= RESET_PC;
            mask_q <= '1;
        end else begin
            st_q   <= st_n;
            pc_q   <= pc_n;
            mask_q <= mask_n;
        end
    end

    // Outputs
    always_comb begin
        pc_o       = pc_q;
        mask_o     = mask_q;
        overflow_o = (st_q == ST_OVF);
    end

    AST_CONV_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONV) |-> (&mask_q)); // R7
    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '0)); // R5
    AST_SPLIT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt != 2'd0) |=> ((mask_q & ~$past(mask_q)) == '0)); // R5
    AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OVF) |=> ($stable(pc_q) && $stable(mask_q) && overflow_o)); // R11

endmodule

// File: tb/simt_reconv_stack_bench.sv
module simt_reconv_stack_bench;

    localparam int LANES = 32;
    localparam int PC_W  = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             adv_i = 1'b0;
    logic             br_valid_i = 1'b0;
    logic [LANES-1:0] br_taken_i = '0;
    logic [PC_W-1:0]  br_target_i = '0;
    logic [PC_W-1:0]  br_rejoin_i = '0;
    logic [PC_W-1:0]  pc_o;
    logic [LANES-1:0] mask_o;
    logic             overflow_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk; // 50 MHz

    simt_reconv_stack u_simt_reconv_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (adv_i),
        .br_valid_i  (br_valid_i),
        .br_taken_i  (br_taken_i),
        .br_target_i (br_target_i),
        .br_rejoin_i (br_rejoin_i),
        .pc_o        (pc_o),
        .mask_o      (mask_o),
        .overflow_o  (overflow_o)
    );

    task automatic chk(input string req, input logic [PC_W-1:0] pc_exp,
                       input logic [LANES-1:0] mask_exp, input logic ovf_exp);
        n_cmp++;
        if (pc_o !== pc_exp || mask_o !== mask_exp || overflow_o !== ovf_exp) begin
            n_bad++;
            $display("FAIL %s: pc=%h mask=%h ovf=%b expected pc=%h mask=%h ovf=%b",
                     req, pc_o, mask_o, overflow_o, pc_exp, mask_exp, ovf_exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        adv_i = 1'b0;
        br_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present one event at a negedge; it is taken at the next posedge.
    task automatic ev(input logic adv, input logic brv, input logic [LANES-1:0] tk,
                      input logic [PC_W-1:0] tgt, input logic [PC_W-1:0] rj);
        adv_i       = adv;
        br_valid_i  = brv;
        br_taken_i  = tk;
        br_target_i = tgt;
        br_rejoin_i = rj;
        @(posedge clk);
        #1;
        adv_i      = 1'b0;
        br_valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic advance();
        ev(1'b1, 1'b0, '0, '0, '0);
    endtask

    task automatic branch(input logic [LANES-1:0] tk, input logic [PC_W-1:0] tgt,
                          input logic [PC_W-1:0] rj);
        ev(1'b0, 1'b1, tk, tgt, rj);
    endtask

    task automatic t_reset_and_advance();
        do_reset();
        chk("R1 reset state", 32'h0, 32'hFFFF_FFFF, 1'b0);
        repeat (3) advance();
        chk("R2 advance x3", 32'hC, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_two_path();
        do_reset();
        repeat (4) advance();
        branch(32'h0000_FFFF, 32'h70, 32'h80);
        chk("R5 divergent taken first", 32'h70, 32'h0000_FFFF, 1'b0);
        branch(32'hFFFF_0000, 32'h300, 32'h400);
        chk("R4 uniform not-taken inactive bits ignored", 32'h74, 32'h0000_FFFF, 1'b0);
        branch(32'h0001_FFFF, 32'h7C, 32'h90);
        chk("R3 uniform taken inactive bits ignored", 32'h7C, 32'h0000_FFFF, 1'b0);
        advance();
        chk("R6 taken path hits rejoin", 32'h14, 32'hFFFF_0000, 1'b0);
        branch(32'hFFFF_FFFF, 32'h80, 32'h999);
        chk("R7 fall path hits rejoin", 32'h80, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        chk("R10 empty stack no pop", 32'h80, 32'hFFFF_FFFF, 1'b0);
        advance();
        chk("R2 advance after rejoin", 32'h84, 32'hFFFF_FFFF, 1'b0);
        branch(32'h0, 32'h500, 32'h600);
        chk("R4 uniform not-taken converged", 32'h88, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_empty_paths();
        do_reset();
        branch(32'h0F0F_0F0F, 32'h20, 32'h20);
        chk("R8 target equals rejoin", 32'h4, 32'hF0F0_F0F0, 1'b0);
        advance();
        chk("R8 fall path advance", 32'h8, 32'hF0F0_F0F0, 1'b0);
        branch(32'hFFFF_FFFF, 32'h20, 32'h0);
        chk("R8 rejoin restores", 32'h20, 32'hFFFF_FFFF, 1'b0);

        do_reset();
        branch(32'h1, 32'h40, 32'h4);
        chk("R9 fall equals rejoin", 32'h40, 32'h1, 1'b0);
        branch(32'h1, 32'h4, 32'h0);
        chk("R9 rejoin restores", 32'h4, 32'hFFFF_FFFF, 1'b0);

        do_reset();
        branch(32'h3, 32'h4, 32'h4);
        chk("R8 both paths empty", 32'h4, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_nested_shared_join();
        do_reset();
        branch(32'h0000_FFFF, 32'h40, 32'h80);
        branch(32'h0000_00FF, 32'h60, 32'h80);
        chk("R5 nested divergence", 32'h60, 32'h0000_00FF, 1'b0);
        branch(32'hFFFF_FFFF, 32'h80, 32'h0);
        chk("R6 inner taken path rejoins", 32'h44, 32'h0000_FF00, 1'b0);
        branch(32'hFFFF_FFFF, 32'h80, 32'h0);
        chk("R7 inner rejoin", 32'h80, 32'h0000_FFFF, 1'b0);
        advance(); // settle cycle: advance must be ignored
        chk("R10 settle pop ignores advance", 32'h4, 32'hFFFF_0000, 1'b0);
        @(negedge clk);
        chk("R10 no further pop", 32'h4, 32'hFFFF_0000, 1'b0);
        branch(32'hFFFF_FFFF, 32'h80, 32'h0);
        chk("R7 outer rejoin", 32'h80, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_overflow();
        do_reset();
        branch(32'h0000_FFFF, 32'h100, 32'h800);
        branch(32'h0000_00FF, 32'h200, 32'h700);
        branch(32'h0000_000F, 32'h300, 32'h600);
        branch(32'h0000_0003, 32'h400, 32'h500);
        chk("R11 four levels fit", 32'h400, 32'h3, 1'b0);
        branch(32'h0000_0001, 32'h480, 32'h4C0);
        chk("R11 overflow raised", 32'h400, 32'h3, 1'b1);
        advance();
        chk("R11 frozen after overflow", 32'h400, 32'h3, 1'b1);
        do_reset();
        chk("R1 reset clears overflow", 32'h0, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_priority();
        do_reset();
        ev(1'b1, 1'b1, 32'hFFFF_FFFF, 32'h30, 32'h99);
        chk("R12 branch beats advance", 32'h30, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run=unfinished expected=finished");
        summary();
        $finish;
    end

    initial begin
        t_reset_and_advance();
        t_two_path();
        t_empty_paths();
        t_nested_shared_join();
        t_overflow();
        t_priority();
        summary();
        $finish;
    end

endmodule